// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block decides when a UART transmitter may start its next character and when the local receiver must ask the far end to pause. It watches the fill level of a 128-entry receive buffer, the stream of received characters and the incoming clear-to-send line. From these it drives the request-to-send line and a gate that permits the next transmit character. It can also ask the serializer to inject an in-band pause or resume character. Hardware handshaking and in-band software handshaking are enabled separately and may run together.

Both kinds of handshaking share one hysteresis state. The receive path becomes "throttled" when the level reaches an upper threshold. It is released only when the level falls to a separate lower threshold. Request-to-send follows this state. The edges of the state queue an injected pause or resume character. On the receive side, the programmed pause and resume characters are acted on and marked for removal from the data stream. An optional mode lets any received character resume a paused transmitter. A programmable match character raises a sticky flag, and a read strobe clears it.

Top module: `uart_flow_ctrl`

## Requirements
- R1: With hardware handshaking enabled (`cfg_hw_en`=1), `cts_i`=0 at a clock edge drives `tx_enable` low one cycle later, and `cts_i`=1 lets it rise again. A character already started by the serializer is not affected, because `tx_enable` only gates the start of the next character.
- R2: With `cfg_hw_en`=1, `rts_o` goes low (deasserted) in the cycle after `rx_level` >= `cfg_hi_thr`. It goes high again only in the cycle after `rx_level` <= `cfg_lo_thr`. For levels strictly between the two thresholds it keeps its value.
- R3: With software handshaking enabled (`cfg_sw_en`=1), receiving `cfg_xoff_char` holds `tx_enable` low from the next cycle on. Receiving `cfg_xon_char` releases that pause. If the two codes are equal, the pause wins.
- R4: With `cfg_sw_en`=1, entering the throttled state queues a pause character (`ins_char`=`cfg_xoff_char`), and leaving it queues a resume character (`ins_char`=`cfg_xon_char`). A newer queued character replaces an older one that has not been sent.
- R5: With `cfg_xon_any`=1 and `cfg_sw_en`=1, any received character other than `cfg_xoff_char` ends a pause.
- R6: Any received byte equal to `cfg_spec_char` while `cfg_spec_en`=1 sets `spec_flag` in the next cycle. `spec_clr` clears it one cycle later, and a new match in the same cycle as `spec_clr` keeps the flag set.
- R7: Levels and thresholds span 0 to 128 inclusive, `rx_level` being 8 bits wide. `cfg_hi_thr`=128 throttles only at a full buffer, and `cfg_lo_thr`=0 releases only at an empty one.
- R8: With `cfg_sw_en`=1, `rx_drop` is high combinationally in the same cycle as an `rx_valid` byte equal to `cfg_xon_char` or `cfg_xoff_char`, so that the byte is kept out of the receive buffer. Otherwise `rx_drop` is 0.
- R9: While a character is queued, `tx_enable` is low so that the queued character goes before buffered data. `ins_valid` is raised only while `tx_busy`=0 and stays up until `ins_ack`, so no character in flight is split.
- R10: After reset `rts_o`=1 when `cfg_hw_en`=1, `tx_enable`=1, `ins_valid`=0 and `spec_flag`=0.
- R11: With `cfg_hw_en`=0, `rts_o` stays 1 and `cts_i` is ignored. With `cfg_sw_en`=0, received pause and resume codes neither pause the transmitter nor raise `rx_drop`, and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_hw_en | input | 1 | Enable RTS/CTS handshaking |
| cfg_sw_en | input | 1 | Enable in-band pause/resume handshaking |
| cfg_xon_any | input | 1 | Any received character resumes |
| cfg_spec_en | input | 1 | Enable match-character detection |
| cfg_hi_thr | input | 8 | Upper level threshold (0..128) |
| cfg_lo_thr | input | 8 | Lower level threshold (0..128) |
| cfg_xon_char | input | 8 | Resume character code |
| cfg_xoff_char | input | 8 | Pause character code |
| cfg_spec_char | input | 8 | Match character code |
| rx_level | input | 8 | Receive buffer fill level |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_drop | output | 1 | Do not store the current received character |
| cts_i | input | 1 | Clear-to-send, 1 = asserted |
| rts_o | output | 1 | Request-to-send, 1 = asserted |
| tx_busy | input | 1 | Serializer is shifting a character |
| tx_enable | output | 1 | Next buffered character may start |
| ins_valid | output | 1 | Inject `ins_char` next |
| ins_char | output | 8 | Character to inject |
| ins_ack | input | 1 | Serializer took the injected character |
| spec_flag | output | 1 | Match character seen |
| spec_clr | input | 1 | Read strobe that clears `spec_flag` |

## Verification
The hardest situation to reach from the ports is a throttle edge that arrives while an injected character is still waiting for the serializer. The new character must replace the old one, and the acknowledge must not clear the replacement. The stimulus drives the fill level as a random walk across narrow, randomly placed threshold windows. It holds `tx_busy` high for long random stretches and acknowledges rarely, so threshold edges pile up on pending characters. Directed sequences cover the full and empty threshold boundaries, equal pause and resume codes, and a match that coincides with a clear strobe.

// File: rtl/uflow_pkg.sv
package uflow_pkg;

    typedef struct packed {
        logic throttle;
    } hyst_state_t;

    typedef struct packed {
        logic xon_pend;
        logic xoff_pend;
    } ins_state_t;

    typedef struct packed {
        logic paused;
        logic spec;
    } rxm_state_t;

    typedef struct packed {
        logic cts;
    } top_state_t;

endpackage

// File: rtl/uflow_hyst.sv
module uflow_hyst
    import uflow_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] hi_thr,
    input  logic [LVL_W-1:0] lo_thr,
    output logic             throttle_o,
    output logic             rise_o,
    output logic             fall_o
);
    hyst_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (level >= hi_thr) begin
            st_d.throttle = 1'b1;
        end else if (level <= lo_thr) begin
            st_d.throttle = 1'b0;
        end
        rise_o = st_d.throttle & ~st_q.throttle;
        fall_o = ~st_d.throttle & st_q.throttle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign throttle_o = st_q.throttle;
endmodule

// File: rtl/uflow_insert.sv
module uflow_insert
    import uflow_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_en,
    input  logic              rise,
    input  logic              fall,
    input  logic              tx_busy,
    input  logic              ack,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    output logic              pend_o,
    output logic              valid_o,
    output logic [CHAR_W-1:0] char_o
);
    ins_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        pend_o  = st_q.xon_pend | st_q.xoff_pend;
        valid_o = pend_o & ~tx_busy;
        char_o  = st_q.xoff_pend ? xoff_char : xon_char;
        if (!sw_en) begin
            st_d = '0;
        end else if (rise) begin
            st_d.xoff_pend = 1'b1;
            st_d.xon_pend  = 1'b0;
        end else if (fall) begin
            st_d.xon_pend  = 1'b1;
            st_d.xoff_pend = 1'b0;
        end else if (valid_o && ack) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uflow_rxmatch.sv
module uflow_rxmatch
    import uflow_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_en,
    input  logic              xon_any,
    input  logic              spec_en,
    input  logic [CHAR_W-1:0] xon_char,
    input  logic [CHAR_W-1:0] xoff_char,
    input  logic [CHAR_W-1:0] spec_char,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              spec_clr,
    output logic              paused_o,
    output logic              spec_o,
    output logic              drop_o
);
    rxm_state_t st_d, st_q;
    logic       is_xon, is_xoff, is_spec;

    always_comb begin
        is_xon  = rx_valid && (rx_data == xon_char);
        is_xoff = rx_valid && (rx_data == xoff_char);
        is_spec = rx_valid && spec_en && (rx_data == spec_char);
        drop_o  = sw_en & (is_xon | is_xoff);
        st_d    = st_q;
        if (!sw_en) begin
            st_d.paused = 1'b0;
        end else if (is_xoff) begin
            st_d.paused = 1'b1;
        end else if (is_xon || (rx_valid && xon_any)) begin
            st_d.paused = 1'b0;
        end
        if (is_spec) begin
            st_d.spec = 1'b1;
        end else if (spec_clr) begin
            st_d.spec = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign paused_o = st_q.paused;
    assign spec_o   = st_q.spec;
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uflow_pkg::*;
#(
    parameter  int FIFO_DEPTH = 128,
    parameter  int CHAR_W     = 8,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hw_en,
    input  logic              cfg_sw_en,
    input  logic              cfg_xon_any,
    input  logic              cfg_spec_en,
    input  logic [LVL_W-1:0]  cfg_hi_thr,
    input  logic [LVL_W-1:0]  cfg_lo_thr,
    input  logic [CHAR_W-1:0] cfg_xon_char,
    input  logic [CHAR_W-1:0] cfg_xoff_char,
    input  logic [CHAR_W-1:0] cfg_spec_char,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_drop,
    input  logic              cts_i,
    output logic              rts_o,
    input  logic              tx_busy,
    output logic              tx_enable,
    output logic              ins_valid,
    output logic [CHAR_W-1:0] ins_char,
    input  logic              ins_ack,
    output logic              spec_flag,
    input  logic              spec_clr
);
    top_state_t st_d, st_q;
    logic throttle, thr_rise, thr_fall, ins_pend, paused;

    uflow_hyst #(.LVL_W(LVL_W)) u_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (rx_level),
        .hi_thr     (cfg_hi_thr),
        .lo_thr     (cfg_lo_thr),
        .throttle_o (throttle),
        .rise_o     (thr_rise),
        .fall_o     (thr_fall)
    );

    uflow_insert #(.CHAR_W(CHAR_W)) u_insert (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_en     (cfg_sw_en),
        .rise      (thr_rise),
        .fall      (thr_fall),
        .tx_busy   (tx_busy),
        .ack       (ins_ack),
        .xon_char  (cfg_xon_char),
        .xoff_char (cfg_xoff_char),
        .pend_o    (ins_pend),
        .valid_o   (ins_valid),
        .char_o    (ins_char)
    );

    uflow_rxmatch #(.CHAR_W(CHAR_W)) u_rxmatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_en     (cfg_sw_en),
        .xon_any   (cfg_xon_any),
        .spec_en   (cfg_spec_en),
        .xon_char  (cfg_xon_char),
        .xoff_char (cfg_xoff_char),
        .spec_char (cfg_spec_char),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .spec_clr  (spec_clr),
        .paused_o  (paused),
        .spec_o    (spec_flag),
        .drop_o    (rx_drop)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cts = cts_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cts: 1'b1};
        else        st_q <= st_d;
    end

    // Gate only the start of the next character; a character in flight runs to its end.
    assign rts_o     = ~(cfg_hw_en & throttle);
    assign tx_enable = ~(cfg_hw_en & ~st_q.cts) & ~paused & ~ins_pend;
endmodule

// File: rtl/uflow_chk.sv
module uflow_chk #(
    parameter int LVL_W  = 8,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_hw_en,
    input logic              cfg_sw_en,
    input logic              cfg_spec_en,
    input logic [LVL_W-1:0]  cfg_hi_thr,
    input logic [LVL_W-1:0]  cfg_lo_thr,
    input logic [CHAR_W-1:0] cfg_xon_char,
    input logic [CHAR_W-1:0] cfg_xoff_char,
    input logic [CHAR_W-1:0] cfg_spec_char,
    input logic [LVL_W-1:0]  rx_level,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_data,
    input logic              rx_drop,
    input logic              cts_i,
    input logic              rts_o,
    input logic              tx_busy,
    input logic              tx_enable,
    input logic              ins_valid,
    input logic              spec_flag
);
    // R1
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hw_en && !cts_i) |=> (!cfg_hw_en || !tx_enable));

    // R2
    rts_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hw_en && rx_level >= cfg_hi_thr) |=> (!cfg_hw_en || !rts_o));

    // R2
    rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level > cfg_lo_thr && rx_level < cfg_hi_thr)
        |=> (!$stable(cfg_hw_en) || $stable(rts_o)));

    // R3
    xoff_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sw_en && rx_valid && rx_data == cfg_xoff_char) |=> !tx_enable);

    // R9
    no_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !ins_valid);

    // R9
    ins_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> !tx_enable);

    // R8
    drop_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sw_en && rx_valid && (rx_data == cfg_xon_char || rx_data == cfg_xoff_char))
        |-> rx_drop);

    // R11
    drop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sw_en |-> !rx_drop);

    // R6
    spec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_spec_en && rx_valid && rx_data == cfg_spec_char) |=> spec_flag);
endmodule

bind uart_flow_ctrl uflow_chk #(.LVL_W(LVL_W), .CHAR_W(CHAR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_hw_en     (cfg_hw_en),
    .cfg_sw_en     (cfg_sw_en),
    .cfg_spec_en   (cfg_spec_en),
    .cfg_hi_thr    (cfg_hi_thr),
    .cfg_lo_thr    (cfg_lo_thr),
    .cfg_xon_char  (cfg_xon_char),
    .cfg_xoff_char (cfg_xoff_char),
    .cfg_spec_char (cfg_spec_char),
    .rx_level      (rx_level),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_drop       (rx_drop),
    .cts_i         (cts_i),
    .rts_o         (rts_o),
    .tx_busy       (tx_busy),
    .tx_enable     (tx_enable),
    .ins_valid     (ins_valid),
    .spec_flag     (spec_flag)
);

// File: tb/tb_uart_flow_ctrl.sv
module tb_uart_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b1, sw_en = 1'b0, xon_any = 1'b0, spec_en = 1'b1;
    logic [7:0] hi_thr = 8'd100, lo_thr = 8'd20;
    logic [7:0] xon_c = 8'h11, xoff_c = 8'h13, spec_c = 8'h7E;
    logic [7:0] level = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       cts = 1'b1, busy = 1'b0, ack = 1'b0, sclr = 1'b0;
    logic       rx_drop, rts, tx_en, ins_v, sflag;
    logic [7:0] ins_c;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench reference state
    bit m_thr, m_xon_p, m_xoff_p, m_paused, m_spec, m_cts;

    always #5 clk = ~clk;

    uart_flow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_hw_en(hw_en), .cfg_sw_en(sw_en),
        .cfg_xon_any(xon_any), .cfg_spec_en(spec_en), .cfg_hi_thr(hi_thr),
        .cfg_lo_thr(lo_thr), .cfg_xon_char(xon_c), .cfg_xoff_char(xoff_c),
        .cfg_spec_char(spec_c), .rx_level(level), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_drop(rx_drop), .cts_i(cts), .rts_o(rts),
        .tx_busy(busy), .tx_enable(tx_en), .ins_valid(ins_v), .ins_char(ins_c),
        .ins_ack(ack), .spec_flag(sflag), .spec_clr(sclr)
    );

    task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic bit f_pend();
        return m_xon_p | m_xoff_p;
    endfunction
    function automatic bit f_rts();
        return !(hw_en && m_thr);
    endfunction
    function automatic bit f_txen();
        return !(hw_en && !m_cts) && !m_paused && !f_pend();
    endfunction
    function automatic bit f_insv();
        return f_pend() && !busy;
    endfunction
    function automatic logic [7:0] f_insc();
        return m_xoff_p ? xoff_c : xon_c;
    endfunction
    function automatic bit f_drop();
        return sw_en && rx_valid && (rx_data == xon_c || rx_data == xoff_c);
    endfunction

    task automatic compare(string tag);
        chk(tag, "rts_o(R2)", {7'd0, rts}, {7'd0, f_rts()});
        chk(tag, "tx_enable(R1,R3,R9)", {7'd0, tx_en}, {7'd0, f_txen()});
        chk(tag, "ins_valid(R4,R9)", {7'd0, ins_v}, {7'd0, f_insv()});
        if (f_pend()) chk(tag, "ins_char(R4)", ins_c, f_insc());
        chk(tag, "spec_flag(R6)", {7'd0, sflag}, {7'd0, m_spec});
    endtask

    // one clock: inputs already set, at a negedge
    task automatic step(string tag);
        bit nthr, rise, fall;
        #1;
        chk(tag, "rx_drop(R8)", {7'd0, rx_drop}, {7'd0, f_drop()});
        nthr = m_thr;
        if (level >= hi_thr) nthr = 1'b1;
        else if (level <= lo_thr) nthr = 1'b0;
        rise = nthr && !m_thr;
        fall = !nthr && m_thr;
        if (!sw_en) begin m_xon_p = 0; m_xoff_p = 0; end
        else if (rise) begin m_xoff_p = 1; m_xon_p = 0; end
        else if (fall) begin m_xon_p = 1; m_xoff_p = 0; end
        else if (f_insv() && ack) begin m_xon_p = 0; m_xoff_p = 0; end
        if (!sw_en) m_paused = 0;
        else if (rx_valid && rx_data == xoff_c) m_paused = 1;
        else if (rx_valid && (rx_data == xon_c || xon_any)) m_paused = 0;
        if (rx_valid && spec_en && rx_data == spec_c) m_spec = 1;
        else if (sclr) m_spec = 0;
        m_thr = nthr;
        m_cts = cts;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        rx_valid = 1'b0; ack = 1'b0; sclr = 1'b0;
    endtask

    task automatic rx(string tag, logic [7:0] c);
        rx_valid = 1'b1; rx_data = c;
        step(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_thr = 0; m_xon_p = 0; m_xoff_p = 0; m_paused = 0; m_spec = 0; m_cts = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R10 reset");

        // R7 / R2: full-range thresholds
        hi_thr = 8'd128; lo_thr = 8'd0;
        level = 8'd127; step("R7 below full");
        level = 8'd128; step("R7 at full");
        level = 8'd64;  step("R2 hold between");
        level = 8'd1;   step("R7 above empty");
        level = 8'd0;   step("R7 at empty");

        // R1: CTS gating
        cts = 1'b0; step("R1 cts low");
        step("R1 cts still low");
        cts = 1'b1; step("R1 cts back");

        // R11: hardware handshaking off
        hw_en = 1'b0; cts = 1'b0; level = 8'd128; step("R11 hw off");
        level = 8'd0; cts = 1'b1; step("R11 hw off release");
        hw_en = 1'b1;

        // R3 / R8: received pause and resume
        sw_en = 1'b1;
        rx("R3 R8 xoff", xoff_c);
        rx("R3 data while paused", 8'h41);
        rx("R3 R8 xon", xon_c);
        // R5: any character resumes
        xon_any = 1'b1;
        rx("R5 xoff", xoff_c);
        rx("R5 any resumes", 8'h42);
        xon_any = 1'b0;

        // R4 / R9: queued characters vs busy serializer
        hi_thr = 8'd60; lo_thr = 8'd10;
        busy = 1'b1; level = 8'd60; step("R4 R9 xoff queued busy");
        busy = 1'b0; step("R9 idle shows xoff");
        level = 8'd5; step("R4 xon replaces xoff");
        ack = 1'b1; step("R9 ack xon");

        // R11: software handshaking off
        sw_en = 1'b0;
        rx("R11 xoff ignored", xoff_c);
        level = 8'd90; step("R11 nothing queued");
        level = 8'd0; step("R11 nothing queued 2");

        // R6: match, clear, and collision
        rx("R6 match", spec_c);
        sclr = 1'b1; step("R6 clear");
        sclr = 1'b1; rx("R6 match wins over clear", spec_c);
        spec_en = 1'b0; rx("R6 disabled", spec_c);
        spec_en = 1'b1; sclr = 1'b1; step("R6 clear again");

        // R3: equal codes, pause wins
        sw_en = 1'b1; xon_c = 8'h13;
        rx("R3 equal codes", 8'h13);
        xon_c = 8'h11;
        rx("R3 release", xon_c);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 2) begin
                int a = $urandom_range(0, 127);
                int b = $urandom_range(a + 1, 128);
                lo_thr = 8'(a); hi_thr = 8'(b);
            end
            if ($urandom_range(0, 199) == 0) hw_en = ~hw_en;
            if ($urandom_range(0, 199) == 0) sw_en = ~sw_en;
            if ($urandom_range(0, 99) == 0) xon_any = ~xon_any;
            if ($urandom_range(0, 3) == 0) begin
                int nl = int'(level) + $urandom_range(0, 8) - 4;
                if (nl < 0) nl = 0;
                if (nl > 128) nl = 128;
                level = 8'(nl);
            end
            if ($urandom_range(0, 9) == 0) cts = ~cts;
            if ($urandom_range(0, 7) == 0) busy = ~busy;
            ack = ($urandom_range(0, 5) == 0);
            sclr = ($urandom_range(0, 9) == 0);
            rx_valid = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 4))
                0: rx_data = xon_c;
                1: rx_data = xoff_c;
                2: rx_data = spec_c;
                default: rx_data = 8'($urandom);
            endcase
            step("RAND");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule